// File: doc/BRIEF.md
# Legacy Interrupt Virtual-Wire Transmitter

This block sits in a bridge between a shared-line parallel bus and a point-to-point packet link. It watches a small set of active-low legacy interrupt lines. Each line may be driven wired-OR by several devices. The link carries no interrupt wires, so the level of each line has to reach the far side as messages. The block turns every change in a line's level into one message code on a ready/valid output, which an outbound message queue consumes. A receiver can then rebuild the level-triggered wire.

Each input first passes through a synchroniser. The block keeps, for each line, the last level it has reported. A line whose synchronised level differs from its reported level has a message pending. The next message is latched into an output register, and the reported level flips in the same cycle. The latched message stays on the port until it is accepted, so a deassert can never be withdrawn or lost while the output is stalled. A line that toggles during a stall is reported in strict alternation, and a full pulse that starts and ends inside a stall collapses to nothing.

Top module: `intx_vwire_tx`

## Requirements
- R1: While reset is active, and in the first cycle after it is released, `msg_valid` is 0. On reset every line's reported level is idle (1).
- R2: When a line i changes from 1 to 0, the block emits an assert message with code 0x20 + i. Line A is i = 0 and line D is i = 3.
- R3: When a line i changes from 0 to 1 after its assert has been sent, the block emits a deassert message with code 0x24 + i.
- R4: The first message reaches the port exactly SYNC_STAGES + 1 rising edges after the input change, counting the edge at which the input is first sampled. This assumes the output is idle.
- R5: When several lines have pending messages, the lowest-numbered line is sent first. The next message is loaded on the same edge that accepts the current one.
- R6: While `msg_valid` is 1 and `msg_ready` is 0, `msg_valid` stays 1 and `msg_code` does not change.
- R7: For any one line, accepted messages strictly alternate, starting with an assert: assert, deassert, assert, and so on.
- R8: A deassert, once the line has returned high after its assert was latched, is always delivered, even after a long stall.
- R9: A line that is already low when reset is released produces an assert.
- R10: If a line falls and returns high while the output is stalled and before its message is latched, no message is produced for that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_n | input | LINES | Raw active-low interrupt lines, bit 0 = line A |
| msg_ready | input | 1 | Outbound queue can take a message |
| msg_valid | output | 1 | A message code is presented |
| msg_code | output | CODE_W | Message code: 0x20+i assert, 0x24+i deassert |

## Verification
The bench builds the block with its defaults: four lines, a two-flop synchroniser and 8-bit codes. That makes the three-edge latency, the fixed 0x20/0x24 code bases and priority across all four lines directly observable. Directed cases cover reset-time low lines, priority collisions, and toggles and pulses hidden inside a stall. A seeded random phase mixes slow line changes with random backpressure, so that per-line alternation and the final drain to idle are checked across many interleavings.

// File: rtl/intx_vwire_tx.sv
module intx_vwire_tx #(
  parameter int LINES = 4,
  parameter int SYNC_STAGES = 2,
  parameter int CODE_W = 8,
  parameter logic [CODE_W-1:0] ASSERT_BASE = 8'h20,
  parameter logic [CODE_W-1:0] DEASSERT_BASE = 8'h24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  irq_n,
  input  logic              msg_ready,
  output logic              msg_valid,
  output logic [CODE_W-1:0] msg_code
);
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1;

  logic [LINES-1:0] sync_q [SYNC_STAGES];
  logic [LINES-1:0] shown_q;
  logic [LINES-1:0] pend;
  logic [IDX_W-1:0] sel;
  logic             load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < SYNC_STAGES; k++) sync_q[k] <= '1;
    end else begin
      sync_q[0] <= irq_n;
      for (int k = 1; k < SYNC_STAGES; k++) sync_q[k] <= sync_q[k-1];
    end
  end

  assign pend = sync_q[SYNC_STAGES-1] ^ shown_q;
  assign load = (|pend) && (!msg_valid || msg_ready);

  always_comb begin
    sel = '0;
    for (int i = LINES - 1; i >= 0; i--)
      if (pend[i]) sel = IDX_W'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shown_q   <= '1;
      msg_valid <= 1'b0;
      msg_code  <= '0;
    end else if (load) begin
      msg_valid    <= 1'b1;
      msg_code     <= shown_q[sel] ? ASSERT_BASE + CODE_W'(sel)
                                   : DEASSERT_BASE + CODE_W'(sel);
      shown_q[sel] <= ~shown_q[sel];
    end else if (msg_ready) begin
      msg_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/intx_vwire_tx_chk.sv
module intx_vwire_tx_chk #(
  parameter int LINES = 4,
  parameter int CODE_W = 8,
  parameter logic [CODE_W-1:0] ASSERT_BASE = 8'h20,
  parameter logic [CODE_W-1:0] DEASSERT_BASE = 8'h24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              msg_valid,
  input logic              msg_ready,
  input logic [CODE_W-1:0] msg_code
);
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !msg_valid);

  a_r6_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_code)));

  a_r2_r3_code_range: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> ((msg_code >= ASSERT_BASE && msg_code < ASSERT_BASE + CODE_W'(LINES)) ||
                   (msg_code >= DEASSERT_BASE && msg_code < DEASSERT_BASE + CODE_W'(LINES))));

  genvar g;
  generate
    for (g = 0; g < LINES; g++) begin : g_line
      logic low_q;
      logic take_a, take_d;
      assign take_a = msg_valid && msg_ready && (msg_code == ASSERT_BASE + CODE_W'(g));
      assign take_d = msg_valid && msg_ready && (msg_code == DEASSERT_BASE + CODE_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) low_q <= 1'b0;
        else if (take_a) low_q <= 1'b1;
        else if (take_d) low_q <= 1'b0;
      end
      a_r7_alternate: assert property (@(posedge clk) disable iff (!rst_n)
        (take_a |-> !low_q) and (take_d |-> low_q));
    end
  endgenerate
endmodule

bind intx_vwire_tx intx_vwire_tx_chk #(
  .LINES(LINES), .CODE_W(CODE_W),
  .ASSERT_BASE(ASSERT_BASE), .DEASSERT_BASE(DEASSERT_BASE)
) chk_i (
  .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid),
  .msg_ready(msg_ready), .msg_code(msg_code)
);

// File: tb/intx_vwire_tx_tb_top.sv
module intx_vwire_tx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LINES = 4;
  localparam int SYNC = 2;
  localparam int LAT = SYNC + 1;

  logic clk = 0, rst_n = 0, msg_ready = 0, msg_valid;
  logic [LINES-1:0] irq_n = '1;
  logic [7:0] msg_code;
  int checks = 0, fails = 0, cycles = 0;
  logic low_seen [LINES];

  always #(CLK_PERIOD/2) clk = ~clk;

  intx_vwire_tx dut_i (.clk(clk), .rst_n(rst_n), .irq_n(irq_n),
    .msg_ready(msg_ready), .msg_valid(msg_valid), .msg_code(msg_code));

  function automatic logic [7:0] code_of(int line, bit is_assert);
    return is_assert ? 8'(8'h20 + line) : 8'(8'h24 + line);
  endfunction

  task automatic chk(string req, logic v, logic [7:0] c, logic ev, logic [7:0] ec);
    checks++;
    if (v !== ev || (ev && c !== ec)) begin
      fails++;
      $display("FAIL %s: valid=%0b code=%02h expected valid=%0b code=%02h", req, v, c, ev, ec);
    end
  endtask

  task automatic accept();
    msg_ready = 1; @(negedge clk); msg_ready = 0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: cycles=%0d expected < 100000", cycles);
      finish_run();
    end
  end

  initial begin
    // R1 and R9: line B low through reset
    irq_n = 4'b1101;
    repeat (3) @(negedge clk);
    chk("R1 in reset", msg_valid, msg_code, 0, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release", msg_valid, msg_code, 0, 0);
    repeat (LAT - 1) @(negedge clk);
    chk("R9 reset-low assert", msg_valid, msg_code, 1, code_of(1, 1));
    accept();
    irq_n = 4'b1111;
    repeat (LAT - 1) @(posedge clk); @(negedge clk);
    chk("R4 early", msg_valid, msg_code, 0, 0);
    @(negedge clk);
    chk("R3 R4 deassert B", msg_valid, msg_code, 1, code_of(1, 0));
    accept();
    chk("R8 idle after drain", msg_valid, msg_code, 0, 0);

    // R5: A and C fall together
    irq_n = 4'b1010;
    repeat (LAT) @(negedge clk);
    chk("R5 first A", msg_valid, msg_code, 1, code_of(0, 1));
    accept();
    chk("R5 then C", msg_valid, msg_code, 1, code_of(2, 1));
    accept();
    irq_n = 4'b1111;
    repeat (LAT) @(negedge clk);
    chk("R3 deassert A", msg_valid, msg_code, 1, code_of(0, 0));
    accept();
    chk("R3 deassert C", msg_valid, msg_code, 1, code_of(2, 0));
    accept();

    // R10 and R6: B pulses while A is stalled
    irq_n = 4'b1110;
    repeat (LAT) @(negedge clk);
    chk("R2 assert A", msg_valid, msg_code, 1, code_of(0, 1));
    irq_n = 4'b1100; @(negedge clk); irq_n = 4'b1110;
    repeat (6) @(negedge clk);
    chk("R6 held during stall", msg_valid, msg_code, 1, code_of(0, 1));
    accept();
    chk("R10 pulse collapsed", msg_valid, msg_code, 0, 0);
    irq_n = 4'b1111;
    repeat (LAT) @(negedge clk);
    chk("R8 deassert A", msg_valid, msg_code, 1, code_of(0, 0));
    accept();

    // R7: D falls, then toggles while stalled, ends high
    irq_n = 4'b0111;
    repeat (LAT) @(negedge clk);
    chk("R2 assert D", msg_valid, msg_code, 1, code_of(3, 1));
    irq_n = 4'b1111; repeat (3) @(negedge clk);
    irq_n = 4'b0111; repeat (3) @(negedge clk);
    irq_n = 4'b1111; repeat (4) @(negedge clk);
    accept();
    chk("R7 alternation D", msg_valid, msg_code, 1, code_of(3, 0));
    accept();
    chk("R7 no repeat D", msg_valid, msg_code, 0, 0);

    // random phase: R7 alternation under random backpressure, R8 drain
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < LINES; i++) low_seen[i] = 0;
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 9) == 0) irq_n[$urandom_range(0, LINES-1)] ^= 1'b1;
      msg_ready = ($urandom_range(0, 2) != 0);
      #1;
      if (msg_valid && msg_ready) begin
        int ln;
        bit as;
        ln = msg_code[1:0];
        as = (msg_code[7:2] == 6'h08);
        checks++;
        if (as == low_seen[ln] || (msg_code[7:2] != 6'h08 && msg_code[7:2] != 6'h09)) begin
          fails++;
          $display("FAIL R7 line %0d: code=%02h expected %02h", ln, msg_code,
                   code_of(ln, !low_seen[ln]));
        end
        low_seen[ln] = as;
      end
      @(negedge clk);
    end
    irq_n = '1;
    msg_ready = 1;
    for (int n = 0; n < 20; n++) begin
      #1;
      if (msg_valid) low_seen[msg_code[1:0]] = (msg_code[7:2] == 6'h08);
      @(negedge clk);
    end
    chk("R8 drained", msg_valid, msg_code, 0, 0);
    for (int i = 0; i < LINES; i++) begin
      checks++;
      if (low_seen[i]) begin
        fails++;
        $display("FAIL R8 line %0d: last=assert expected deassert", i);
      end
    end
    finish_run();
  end
endmodule